// File: doc/BRIEF.md
# Interworking Program Counter Unit

This block owns the program counter and the instruction-set state of a core that runs two encodings: a wide mode, where every instruction is four bytes and word aligned, and a compact mode, where instructions are two or four bytes and halfword aligned. In every clock cycle the unit does one of four things. It holds, it steps to the next sequential instruction, it takes a plain branch that keeps the current mode, or it takes a mode-switching indirect branch. In a mode-switching branch, the lowest bit of the target chooses the mode and is removed before the target is written to the PC.

Alignment is enforced on every write to the PC, using the rule of the mode that is in force after the write. The parameter `COMPACT_ONLY` builds a profile that can only run compact mode. In that profile, a switching branch that asks for wide mode does not change anything and raises a fault pulse instead.

The surrounding pipeline drives the request strobes and the branch target. It also supplies the byte length of the instruction at the current PC, which is needed for sequential stepping in compact mode.

Top module: `ilw_pc_unit`

## Requirements
- R1: While `rst_n` is low, and after its release until the first request, `pc_o` equals `RESET_ADDR` aligned for the reset mode and `fault_o` is 0. The reset mode is wide (`compact_o`=0) in the full profile.
- R2: On a mode-switching branch (`xbr_i`=1), the next `compact_o` equals bit 0 of `tgt_i`: 0 selects wide mode and 1 selects compact mode. This holds both when the mode stays the same and when it changes.
- R3: A mode-switching branch loads `pc_o` from `tgt_i` with bit 0 cleared. When the new mode is wide, bit 1 is also cleared. Bit 0 of `pc_o` is always 0, and in wide mode bits [1:0] of `pc_o` are always 00.
- R4: In wide mode, a sequential step (`adv_i`=1) adds 4 to `pc_o`, whatever the value of `len4_i`.
- R5: In compact mode, a sequential step adds 2 when `len4_i`=0 and adds 4 when `len4_i`=1.
- R6: A plain branch (`br_i`=1) keeps the current mode. It loads `tgt_i` with bits [1:0] cleared in wide mode, and with only bit 0 cleared in compact mode.
- R7: When more than one request is raised in a cycle, `xbr_i` wins over `br_i`, and `br_i` wins over `adv_i`.
- R8: With no request raised, `pc_o` and `compact_o` keep their values.
- R9: With `COMPACT_ONLY`=1, a switching branch whose target bit 0 is 0 leaves `pc_o` and `compact_o` unchanged. In that case `fault_o` is 1 during exactly the cycle after the request. `fault_o` is 1 at no other time, and never in the full profile.
- R10: With `COMPACT_ONLY`=1, the reset mode is compact, `compact_o` stays 1, and a switching branch whose target bit 0 is 1 loads the target with bit 0 cleared.
- R11: PC arithmetic wraps modulo 2^`ADDR_W`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adv_i | input | 1 | Step to the next sequential instruction |
| br_i | input | 1 | Plain branch to `tgt_i`, mode kept |
| xbr_i | input | 1 | Mode-switching branch, `tgt_i[0]` selects the mode |
| tgt_i | input | ADDR_W | Branch target address |
| len4_i | input | 1 | Current instruction is 4 bytes (used in compact mode) |
| pc_o | output | ADDR_W | Program counter |
| compact_o | output | 1 | 1 = compact mode, 0 = wide mode |
| fault_o | output | 1 | One-cycle pulse for a refused switch to wide mode |

## Verification
The bench builds two instances side by side. The first uses the default full profile (`COMPACT_ONLY`=0), which makes every mode transition reachable: staying in and leaving wide mode, staying in and leaving compact mode, and the alignment of each. It also confirms that the fault line never moves in this profile. The second uses `COMPACT_ONLY`=1 with the same reset address, which brings the refused switch, the fault pulse and its lack of effect on the PC within reach, along with the compact reset mode.

// File: rtl/ilw_pc_pkg.sv
// Package ilw_pc_pkg
// Shared types for the interworking program counter unit: the mode encoding
// and the per-cycle operation selected from the request strobes.
// Assumes: the mode encoding 0 = wide, 1 = compact matches bit 0 of a
// switching branch target.
package ilw_pc_pkg;

    typedef enum logic {
        ISA_WIDE    = 1'b0,
        ISA_COMPACT = 1'b1
    } isa_e;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SEQ   = 2'd1,
        OP_JUMP  = 2'd2,
        OP_XJUMP = 2'd3
    } pc_op_e;

endpackage

// File: rtl/ilw_req_select.sv
// Module ilw_req_select
// Turns the three request strobes into a single operation. The priority is
// fixed: mode-switching branch, then plain branch, then sequential step.
// Assumes: the strobes may be raised in any combination.
module ilw_req_select
    import ilw_pc_pkg::*;
(
    input  logic   adv_i,
    input  logic   br_i,
    input  logic   xbr_i,
    output pc_op_e op_o
);

    // Priority pick of one operation per cycle.
    always_comb begin
        if (xbr_i) begin
            op_o = OP_XJUMP;
        end else if (br_i) begin
            op_o = OP_JUMP;
        end else if (adv_i) begin
            op_o = OP_SEQ;
        end else begin
            op_o = OP_HOLD;
        end
    end

endmodule

// File: rtl/ilw_step_adder.sv
// Module ilw_step_adder
// Computes the sequential successor of the PC. Wide mode always steps by 4.
// Compact mode steps by 2 or 4, depending on the reported instruction length.
// Assumes: the sum wraps modulo 2^ADDR_W.
module ilw_step_adder
    import ilw_pc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  isa_e              isa_i,
    input  logic              len4_i,
    output logic [ADDR_W-1:0] sum_o
);

    localparam logic [ADDR_W-1:0] STEP_HALF = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(4);

    logic [ADDR_W-1:0] step;

    // Select the step size from the mode and the instruction length.
    always_comb begin
        if (isa_i == ISA_COMPACT && !len4_i) begin
            step = STEP_HALF;
        end else begin
            step = STEP_WORD;
        end
    end

    // Modular add of the step.
    always_comb begin
        sum_o = pc_i + step;
    end

endmodule

// File: rtl/ilw_next_pc.sv
// Module ilw_next_pc
// Works out the next PC, mode and fault from the chosen operation. Every
// value written to the PC is aligned for the mode in force after the write.
// The COMPACT_ONLY generate branch replaces a switch to wide mode with a
// fault that leaves the state as it is.
// Assumes: op_i comes from ilw_req_select, and sum_i is the sequential
// successor of pc_i.
module ilw_next_pc
    import ilw_pc_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter bit COMPACT_ONLY = 1'b0
) (
    input  pc_op_e            op_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  isa_e              isa_i,
    input  logic [ADDR_W-1:0] tgt_i,
    input  logic [ADDR_W-1:0] sum_i,
    output logic [ADDR_W-1:0] pc_nxt_o,
    output isa_e              isa_nxt_o,
    output logic              fault_nxt_o
);

    localparam logic [ADDR_W-1:0] MASK_HALF = ~ADDR_W'(1);
    localparam logic [ADDR_W-1:0] MASK_WORD = ~ADDR_W'(3);

    logic [ADDR_W-1:0] jump_tgt;
    logic [ADDR_W-1:0] xjump_tgt;
    isa_e              xjump_isa;
    logic              xjump_refused;

    // Plain branch target, aligned for the current mode.
    always_comb begin
        jump_tgt = (isa_i == ISA_COMPACT) ? (tgt_i & MASK_HALF)
                                          : (tgt_i & MASK_WORD);
    end

    // Mode requested by a switching branch, taken from target bit 0.
    always_comb begin
        xjump_isa = tgt_i[0] ? ISA_COMPACT : ISA_WIDE;
    end

    // Switching branch target, with the selector stripped and aligned for
    // the requested mode.
    always_comb begin
        xjump_tgt = (xjump_isa == ISA_COMPACT) ? (tgt_i & MASK_HALF)
                                               : (tgt_i & MASK_WORD);
    end

    // Profile variant: decide whether a switch to wide mode is refused.
    generate
        if (COMPACT_ONLY) begin : g_compact_only
            always_comb begin
                xjump_refused = (xjump_isa == ISA_WIDE);
            end
        end else begin : g_full
            always_comb begin
                xjump_refused = 1'b0;
            end
        end
    endgenerate

    // Final selection of the next state.
    always_comb begin
        pc_nxt_o    = pc_i;
        isa_nxt_o   = isa_i;
        fault_nxt_o = 1'b0;
        unique case (op_i)
            OP_SEQ: begin
                pc_nxt_o = sum_i;
            end
            OP_JUMP: begin
                pc_nxt_o = jump_tgt;
            end
            OP_XJUMP: begin
                if (xjump_refused) begin
                    fault_nxt_o = 1'b1;
                end else begin
                    pc_nxt_o  = xjump_tgt;
                    isa_nxt_o = xjump_isa;
                end
            end
            default: begin
                pc_nxt_o = pc_i;
            end
        endcase
    end

endmodule

// File: rtl/ilw_pc_unit.sv
// Module ilw_pc_unit
// Top of the interworking program counter unit. It holds the PC, the mode
// flag and the registered fault pulse, and updates them once per cycle from
// the request strobes.
// Assumes: synchronous active-low reset. RESET_ADDR is masked to the
// alignment of the reset mode.
module ilw_pc_unit
    import ilw_pc_pkg::*;
#(
    parameter int                ADDR_W       = 32,
    parameter logic [ADDR_W-1:0] RESET_ADDR   = 32'h0000_0100,
    parameter bit                COMPACT_ONLY = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic              br_i,
    input  logic              xbr_i,
    input  logic [ADDR_W-1:0] tgt_i,
    input  logic              len4_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic              compact_o,
    output logic              fault_o
);

    localparam isa_e              RESET_ISA = COMPACT_ONLY ? ISA_COMPACT : ISA_WIDE;
    localparam logic [ADDR_W-1:0] RESET_PC  = COMPACT_ONLY ? (RESET_ADDR & ~ADDR_W'(1))
                                                           : (RESET_ADDR & ~ADDR_W'(3));

    pc_op_e            op;
    isa_e              isa_q;
    isa_e              isa_nxt;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_nxt;
    logic [ADDR_W-1:0] seq_sum;
    logic              fault_q;
    logic              fault_nxt;

    ilw_req_select u_sel (
        .adv_i (adv_i),
        .br_i  (br_i),
        .xbr_i (xbr_i),
        .op_o  (op)
    );

    ilw_step_adder #(
        .ADDR_W (ADDR_W)
    ) u_step (
        .pc_i   (pc_q),
        .isa_i  (isa_q),
        .len4_i (len4_i),
        .sum_o  (seq_sum)
    );

    ilw_next_pc #(
        .ADDR_W       (ADDR_W),
        .COMPACT_ONLY (COMPACT_ONLY)
    ) u_next (
        .op_i        (op),
        .pc_i        (pc_q),
        .isa_i       (isa_q),
        .tgt_i       (tgt_i),
        .sum_i       (seq_sum),
        .pc_nxt_o    (pc_nxt),
        .isa_nxt_o   (isa_nxt),
        .fault_nxt_o (fault_nxt)
    );

    // State registers: PC, mode and fault pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= RESET_PC;
            isa_q   <= RESET_ISA;
            fault_q <= 1'b0;
        end else begin
            pc_q    <= pc_nxt;
            isa_q   <= isa_nxt;
            fault_q <= fault_nxt;
        end
    end

    // Drive the outputs from the registers.
    always_comb begin
        pc_o      = pc_q;
        compact_o = (isa_q == ISA_COMPACT);
        fault_o   = fault_q;
    end

endmodule

// File: rtl/ilw_pc_unit_chk.sv
// Module ilw_pc_unit_chk
// Property checker for ilw_pc_unit, attached through bind. It observes only
// the ports of the unit.
// Assumes: synchronous active-low reset.
module ilw_pc_unit_chk #(
    parameter int ADDR_W       = 32,
    parameter bit COMPACT_ONLY = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adv_i,
    input logic              br_i,
    input logic              xbr_i,
    input logic [ADDR_W-1:0] tgt_i,
    input logic              len4_i,
    input logic [ADDR_W-1:0] pc_o,
    input logic              compact_o,
    input logic              fault_o
);

    AST_PC_HALF_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_o[0]); // R3

    AST_WIDE_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        !compact_o |-> (pc_o[1:0] == 2'b00)); // R3

    AST_SWITCH_PICKS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (xbr_i && (tgt_i[0] || !COMPACT_ONLY)) |=> (compact_o == $past(tgt_i[0]))); // R2

    AST_JUMP_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (br_i && !xbr_i) |=> (compact_o == $past(compact_o))); // R6

    AST_WIDE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !br_i && !xbr_i && !compact_o) |=> (pc_o == $past(pc_o) + ADDR_W'(4))); // R4

    AST_COMPACT_SHORT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !br_i && !xbr_i && compact_o && !len4_i) |=> (pc_o == $past(pc_o) + ADDR_W'(2))); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !br_i && !xbr_i) |=> ($stable(pc_o) && $stable(compact_o))); // R8

    AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> ($past(xbr_i) && !$past(tgt_i[0]))); // R9

    AST_FAULT_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> ($stable(pc_o) && $stable(compact_o))); // R9

    AST_FULL_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (COMPACT_ONLY == 1'b0) |-> !fault_o); // R9

    AST_COMPACT_ONLY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (COMPACT_ONLY == 1'b1) |-> compact_o); // R10

endmodule

bind ilw_pc_unit ilw_pc_unit_chk #(
    .ADDR_W       (ADDR_W),
    .COMPACT_ONLY (COMPACT_ONLY)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv_i     (adv_i),
    .br_i      (br_i),
    .xbr_i     (xbr_i),
    .tgt_i     (tgt_i),
    .len4_i    (len4_i),
    .pc_o      (pc_o),
    .compact_o (compact_o),
    .fault_o   (fault_o)
);

// File: tb/ilw_pc_unit_tb.sv
// Directed bench for ilw_pc_unit: one full-profile instance (dut_i) and one
// compact-only instance (dut_c_i), each driven by its own inputs.
module ilw_pc_unit_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam int          AW         = 32;
    localparam logic [31:0] RST_ADDR   = 32'h0000_0100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic          a_adv = 0, a_br = 0, a_xbr = 0, a_len4 = 0;
    logic [AW-1:0] a_tgt = '0;
    logic [AW-1:0] a_pc;
    logic          a_cmp, a_flt;

    logic          c_adv = 0, c_br = 0, c_xbr = 0, c_len4 = 0;
    logic [AW-1:0] c_tgt = '0;
    logic [AW-1:0] c_pc;
    logic          c_cmp, c_flt;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ilw_pc_unit #(.ADDR_W(AW), .RESET_ADDR(RST_ADDR), .COMPACT_ONLY(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .adv_i(a_adv), .br_i(a_br), .xbr_i(a_xbr),
        .tgt_i(a_tgt), .len4_i(a_len4), .pc_o(a_pc), .compact_o(a_cmp), .fault_o(a_flt));

    ilw_pc_unit #(.ADDR_W(AW), .RESET_ADDR(RST_ADDR), .COMPACT_ONLY(1'b1)) dut_c_i (
        .clk(clk), .rst_n(rst_n), .adv_i(c_adv), .br_i(c_br), .xbr_i(c_xbr),
        .tgt_i(c_tgt), .len4_i(c_len4), .pc_o(c_pc), .compact_o(c_cmp), .fault_o(c_flt));

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, got, exp);
        end
    endtask

    // Full-profile cycle: drive at a negedge, let one posedge pass, clear.
    task automatic step_a(input logic adv, input logic br, input logic xbr,
                          input logic [31:0] tgt, input logic len4);
        a_adv = adv; a_br = br; a_xbr = xbr; a_tgt = tgt; a_len4 = len4;
        @(negedge clk);
        a_adv = 0; a_br = 0; a_xbr = 0; a_tgt = '0; a_len4 = 0;
    endtask

    task automatic step_c(input logic adv, input logic br, input logic xbr,
                          input logic [31:0] tgt, input logic len4);
        c_adv = adv; c_br = br; c_xbr = xbr; c_tgt = tgt; c_len4 = len4;
        @(negedge clk);
        c_adv = 0; c_br = 0; c_xbr = 0; c_tgt = '0; c_len4 = 0;
    endtask

    task automatic t_reset();
        check("R1", "full pc", a_pc, RST_ADDR);
        check("R1", "full mode", 32'(a_cmp), 32'd0);
        check("R1", "full fault", 32'(a_flt), 32'd0);
        check("R10", "compact-only pc", c_pc, RST_ADDR);
        check("R10", "compact-only mode", 32'(c_cmp), 32'd1);
        check("R1", "compact-only fault", 32'(c_flt), 32'd0);
    endtask

    task automatic t_wide_advance();
        step_a(1, 0, 0, '0, 0);
        check("R4", "wide step len2", a_pc, 32'h104);
        step_a(1, 0, 0, '0, 1);
        check("R4", "wide step len4", a_pc, 32'h108);
    endtask

    task automatic t_wide_jump();
        step_a(0, 1, 0, 32'h2003, 0);
        check("R6", "wide jump pc", a_pc, 32'h2000);
        check("R6", "wide jump mode", 32'(a_cmp), 32'd0);
    endtask

    task automatic t_switch_sequence();
        step_a(0, 0, 1, 32'h3006, 0);
        check("R3", "stay wide pc", a_pc, 32'h3004);
        check("R2", "stay wide mode", 32'(a_cmp), 32'd0);
        step_a(0, 0, 1, 32'h4003, 0);
        check("R3", "enter compact pc", a_pc, 32'h4002);
        check("R2", "enter compact mode", 32'(a_cmp), 32'd1);
        step_a(1, 0, 0, '0, 0);
        check("R5", "compact step 2", a_pc, 32'h4004);
        step_a(1, 0, 0, '0, 1);
        check("R5", "compact step 4", a_pc, 32'h4008);
        step_a(0, 1, 0, 32'h5007, 0);
        check("R6", "compact jump pc", a_pc, 32'h5006);
        check("R6", "compact jump mode", 32'(a_cmp), 32'd1);
        step_a(0, 0, 1, 32'h6001, 0);
        check("R3", "stay compact pc", a_pc, 32'h6000);
        check("R2", "stay compact mode", 32'(a_cmp), 32'd1);
        step_a(0, 0, 1, 32'h7006, 0);
        check("R3", "leave compact pc", a_pc, 32'h7004);
        check("R2", "leave compact mode", 32'(a_cmp), 32'd0);
    endtask

    task automatic t_priority();
        step_a(1, 1, 1, 32'h8001, 0);
        check("R7", "xbr wins pc", a_pc, 32'h8000);
        check("R7", "xbr wins mode", 32'(a_cmp), 32'd1);
        step_a(1, 1, 0, 32'h9003, 0);
        check("R7", "br beats adv pc", a_pc, 32'h9002);
    endtask

    task automatic t_idle();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
        end
        check("R8", "idle pc", a_pc, 32'h9002);
        check("R8", "idle mode", 32'(a_cmp), 32'd1);
        check("R9", "full fault never", 32'(a_flt), 32'd0);
    endtask

    task automatic t_wrap();
        step_a(0, 1, 0, 32'hFFFF_FFFF, 0);
        check("R6", "high jump pc", a_pc, 32'hFFFF_FFFE);
        step_a(1, 0, 0, '0, 0);
        check("R11", "wrap pc", a_pc, 32'h0);
    endtask

    task automatic t_full_switch_to_wide_no_fault();
        step_a(0, 0, 1, 32'hA000, 0);
        check("R9", "full switch pc", a_pc, 32'hA000);
        check("R9", "full switch fault", 32'(a_flt), 32'd0);
    endtask

    task automatic t_compact_only();
        step_c(0, 0, 1, 32'hA000, 0);
        check("R9", "refused pc", c_pc, RST_ADDR);
        check("R9", "refused mode", 32'(c_cmp), 32'd1);
        check("R9", "fault pulse", 32'(c_flt), 32'd1);
        @(negedge clk);
        check("R9", "fault drops", 32'(c_flt), 32'd0);
        step_c(0, 0, 1, 32'hB003, 0);
        check("R10", "allowed switch pc", c_pc, 32'hB002);
        check("R10", "allowed switch mode", 32'(c_cmp), 32'd1);
        check("R9", "no fault on allowed", 32'(c_flt), 32'd0);
        step_c(1, 0, 0, '0, 0);
        check("R5", "compact-only step", c_pc, 32'hB004);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wide_advance();
        t_wide_jump();
        t_switch_sequence();
        t_priority();
        t_idle();
        t_wrap();
        t_full_switch_to_wide_no_fault();
        t_compact_only();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule